// File: doc/BRIEF.md
# Parity-Checked SPI Register Slave

This block lets an SPI host read and write a small bank of 8-bit registers through 16-bit frames. The host lowers chip select and clocks in a command byte: a 6-bit address, an operation bit and an odd-parity bit. A data byte follows. While the command arrives, the block shifts out a status byte. While the data byte arrives, it shifts out the current contents of the addressed register. A write frame therefore returns the value the register held before the write.

A write takes effect only when chip select returns high, and only if the frame had exactly sixteen clock edges and correct command parity. Any other frame is dropped and raises an error flag, which the next frame reports in its status byte. A power-on flag tells the host that the device has been reset since its last good frame. Two status bits come from outside the block and are only carried through. A control register can silence the serial output, so that a host can broadcast one write to several slaves on a shared line. The SPI lines are oversampled by a faster system clock, after a parameterised synchronizer.

Top module: `spi_parity_regif`

## Requirements
- R1: A frame is 16 bits, MSB first on both lines, in SPI mode 0. The command byte holds A5..A0 in bits 1-6, the operation in bit 7 (1 = write, 0 = read) and, in bit 8, a parity bit that gives bits 1-8 an odd number of ones. The second byte is write data, and it is ignored on reads.
- R2: The first output byte, MSB first, is {0, frame_error, power_on, self_test, saturation, 0, 1, dpar}. dpar gives the 8 data bits of the same frame plus dpar an odd number of ones.
- R3: The second output byte is the addressed register's value at the start of the frame. On a write it is the old contents.
- R4: A write is stored only when chip select rises after exactly 16 SCK rising edges with correct command parity. Any other frame leaves every register unchanged.
- R5: An invalid frame (wrong parity, or a rising-edge count other than 16) makes the next frame report frame_error = 1. A valid frame makes the next frame report 0.
- R6: power_on reads 1 after reset. It is cleared when the first valid frame completes, so the frame after that reports 0.
- R7: Addresses 0x00-0x07 are registers that reset to 0x00. Every other address reads 0x00 and ignores writes.
- R8: The MISO output enable is low whenever chip select is high, including after reset.
- R9: When bit 0 of register 0x00 is 1, the MISO output enable stays low during frames too. Writes are still accepted, so a broadcast write can clear the bit.
- R10: The self_test and saturation inputs are captured into the status byte when chip select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock, idle low |
| csb_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| self_test_i | input | 1 | Self-test error status bit to report |
| sat_i | input | 1 | Saturation status bit to report |
| miso_o | output | 1 | Serial data to the host, forced to 0 when not enabled |
| miso_oe_o | output | 1 | Output enable for the external MISO tri-state driver |

## Verification
The assertions assume the SPI lines are slow compared with the system clock. Every SCK level lasts longer than the synchronizer depth plus two system cycles, SCK is low whenever chip select changes, and no SCK edge falls in the same system cycle as a chip-select edge. Under these conditions every serial edge appears as exactly one one-cycle pulse. The bench moves each SPI line on a falling system-clock edge, eight system cycles apart, and it changes the two status inputs only while chip select is high.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } spi_op_e;

   // Bit that makes the word plus this bit contain an odd number of ones.
   function automatic logic odd_fill(input logic [7:0] v);
      return ~(^v);
   endfunction

endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic q
);

   logic [STAGES-1:0] pipe_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[0] <= RST_VAL;
               else        pipe_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[s] <= RST_VAL;
               else        pipe_q[s] <= pipe_q[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import spi_regif_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              csb_s,
   input  logic              mosi_s,
   input  logic [DATA_W-2:0] stat_in,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              frame_end,
   output logic              frame_ok,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso
);

   localparam int CMD_W      = ADDR_W + 2;
   localparam int FRAME_BITS = CMD_W + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS) + 2;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic                  sck_d, csb_d;
   logic                  sck_rise, sck_fall, csb_fall;
   logic [FRAME_BITS-1:0] shreg_q, next_sh;
   logic [CNT_W-1:0]      rise_cnt_q, fall_cnt_q;
   logic [DATA_W-2:0]     stat_q;
   logic [DATA_W-1:0]     data_q;
   logic [CMD_W-1:0]      cmd;
   logic [FRAME_BITS-1:0] out_word;
   logic [IDX_W-1:0]      out_idx;
   spi_op_e               op;

   assign sck_rise  =  sck_s & ~sck_d & ~csb_s;
   assign sck_fall  = ~sck_s &  sck_d & ~csb_s;
   assign csb_fall  = ~csb_s &  csb_d;
   assign frame_end =  csb_s & ~csb_d;

   assign next_sh = {shreg_q[FRAME_BITS-2:0], mosi_s};
   assign rd_addr = next_sh[ADDR_W-1:0];

   assign cmd      = shreg_q[FRAME_BITS-1:DATA_W];
   assign op       = spi_op_e'(cmd[1]);
   assign frame_ok = (rise_cnt_q == CNT_W'(FRAME_BITS)) && (^cmd);
   assign wr_en    = frame_end && frame_ok && (op == OP_WRITE);
   assign wr_addr  = cmd[CMD_W-1:2];
   assign wr_data  = shreg_q[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d      <= 1'b0;
         csb_d      <= 1'b1;
         shreg_q    <= '0;
         rise_cnt_q <= '0;
         fall_cnt_q <= '0;
         stat_q     <= '0;
         data_q     <= '0;
      end else begin
         sck_d <= sck_s;
         csb_d <= csb_s;
         if (csb_fall) begin
            rise_cnt_q <= '0;
            fall_cnt_q <= '0;
            stat_q     <= stat_in;
            data_q     <= '0;
         end else begin
            if (sck_rise) begin
               shreg_q <= next_sh;
               if (rise_cnt_q != CNT_MAX) rise_cnt_q <= rise_cnt_q + 1'b1;
               if (rise_cnt_q == CNT_W'(ADDR_W - 1)) data_q <= rd_data;
            end
            if (sck_fall && fall_cnt_q != CNT_MAX) fall_cnt_q <= fall_cnt_q + 1'b1;
         end
      end
   end

   assign out_word = {stat_q, odd_fill(data_q), data_q};
   assign out_idx  = IDX_W'(FRAME_BITS - 1) - fall_cnt_q[IDX_W-1:0];
   assign miso     = (fall_cnt_q < CNT_W'(FRAME_BITS)) ? out_word[out_idx] : 1'b0;

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic [ADDR_W-1:0]               rd_addr,
   output logic [DATA_W-1:0]               rd_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   regs_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))      regs_q[i] <= wr_data;
         end
      end
   endgenerate

   // Unimplemented addresses fall through to zero.
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
      end
   end

endmodule

// File: rtl/spi_parity_regif.sv
module spi_parity_regif #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int NUM_REGS    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ODIS_BIT    = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic csb_i,
   input  logic mosi_i,
   input  logic self_test_i,
   input  logic sat_i,
   output logic miso_o,
   output logic miso_oe_o
);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("spi_parity_regif: status byte layout needs DATA_W == 8");
      end
      if (ADDR_W + 2 != DATA_W) begin : g_bad_addr_w
         $error("spi_parity_regif: command byte must be as wide as the data byte");
      end
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
         $error("spi_parity_regif: NUM_REGS out of address range");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("spi_parity_regif: need at least one sync stage");
      end
      if (ODIS_BIT < 0 || ODIS_BIT >= DATA_W) begin : g_bad_odis
         $error("spi_parity_regif: ODIS_BIT outside control register");
      end
   endgenerate

   logic sck_s, csb_s, mosi_s;
   logic frame_end, frame_ok, wr_en;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic [NUM_REGS-1:0][DATA_W-1:0] bank_flat;
   logic [DATA_W-2:0] stat_in;
   logic frme_q, porst_q, miso_raw;

   spi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .din(sck_i), .q(sck_s));
   spi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csb (
      .clk(clk), .rst_n(rst_n), .din(csb_i), .q(csb_s));
   spi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .din(mosi_i), .q(mosi_s));

   assign stat_in = {1'b0, frme_q, porst_q, self_test_i, sat_i, 1'b0, 1'b1};

   spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .sck_s(sck_s), .csb_s(csb_s), .mosi_s(mosi_s),
      .stat_in(stat_in), .rd_data(rd_data), .rd_addr(rd_addr),
      .frame_end(frame_end), .frame_ok(frame_ok),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .miso(miso_raw));

   spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .regs_q(bank_flat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frme_q  <= 1'b0;
         porst_q <= 1'b1;
      end else if (frame_end) begin
         frme_q <= ~frame_ok;
         if (frame_ok) porst_q <= 1'b0;
      end
   end

   assign miso_oe_o = ~csb_s & ~bank_flat[0][ODIS_BIT];
   assign miso_o    = miso_oe_o & miso_raw;

endmodule

// File: rtl/spi_parity_regif_chk.sv
module spi_parity_regif_chk #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 8,
   parameter int ODIS_BIT = 0
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            csb_i,
   input logic                            miso_oe_o,
   input logic                            frame_end,
   input logic                            frame_ok,
   input logic                            wr_en,
   input logic [NUM_REGS-1:0][DATA_W-1:0] bank_flat,
   input logic                            porst_q,
   input logic                            frme_q
);

   AST_IDLE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (csb_i && $past(csb_i) && $past(csb_i, 2)) |-> !miso_oe_o); // R8

   AST_WRITE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank_flat) |-> $past(wr_en)); // R4

   AST_BAD_FRAME_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !frame_ok) |=> frme_q); // R5

   AST_GOOD_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame_ok) |=> (!frme_q && !porst_q)); // R6

   AST_PORST_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !porst_q |=> !porst_q); // R6

   AST_OUTPUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bank_flat[0][ODIS_BIT]) && bank_flat[0][ODIS_BIT]) |-> !miso_oe_o); // R9

endmodule

bind spi_parity_regif spi_parity_regif_chk #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ODIS_BIT(ODIS_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .csb_i(csb_i), .miso_oe_o(miso_oe_o),
   .frame_end(frame_end), .frame_ok(frame_ok), .wr_en(wr_en),
   .bank_flat(bank_flat), .porst_q(porst_q), .frme_q(frme_q)
);

// File: tb/spi_parity_regif_tb.sv
module spi_parity_regif_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, csb = 1'b1, mosi = 1'b0, st = 1'b0, sat = 1'b0;
   logic miso, oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] mem [0:7];
   logic frme_m, porst_m;
   logic [7:0] last_stat, last_data;

   always #2.5 clk = ~clk;

   spi_parity_regif dut_i (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .csb_i(csb), .mosi_i(mosi),
      .self_test_i(st), .sat_i(sat), .miso_o(miso), .miso_oe_o(oe));

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic run_frame(input logic [15:0] word, input int nbits,
                            output logic [15:0] got, output bit oe_any, output bit oe_all);
      got = '0; oe_any = 1'b0; oe_all = 1'b1;
      csb = 1'b0;
      wait_clk(8);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 16) ? word[15-i] : 1'b0;
         wait_clk(8);
         if (i < 16) begin
            got[15-i] = miso;
            oe_any |= oe;
            oe_all &= oe;
         end
         sck = 1'b1;
         wait_clk(8);
         sck = 1'b0;
      end
      wait_clk(8);
      csb = 1'b1;
      wait_clk(12);
   endtask

   task automatic do_frame(input logic [5:0] a, input bit wr, input logic [7:0] d,
                           input int nbits, input bit badpar, input bit st_v,
                           input bit sat_v, input string dtag);
      logic [15:0] word, got;
      logic [7:0] exp_d, exp_s;
      bit oe_any, oe_all, valid;
      exp_d = (a < 6'd8) ? mem[a[2:0]] : 8'h00;
      exp_s = {1'b0, frme_m, porst_m, st_v, sat_v, 1'b0, 1'b1, ~(^exp_d)};
      word  = {a, wr, ~(^{a, wr}), d};
      if (badpar) word[8] = ~word[8];
      st = st_v; sat = sat_v;
      wait_clk(2);
      run_frame(word, nbits, got, oe_any, oe_all);
      if (!mem[0][0]) begin
         check("R9", "output enabled during frame", 16'(oe_all), 16'd1);
         if (nbits >= 8)  check("R2", "status byte", 16'(got[15:8]), 16'(exp_s));
         if (nbits >= 16) check(dtag, "data byte", 16'(got[7:0]), 16'(exp_d));
      end else begin
         check("R9", "output silenced", 16'(oe_any), 16'd0);
      end
      check("R8", "enable low when idle", 16'(oe), 16'd0);
      last_stat = got[15:8];
      last_data = got[7:0];
      valid = (nbits == 16) && !badpar;
      if (valid && wr && a < 6'd8) mem[a[2:0]] = d;
      frme_m = !valid;
      if (valid) porst_m = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      for (int i = 0; i < 8; i++) mem[i] = 8'h00;
      frme_m = 1'b0; porst_m = 1'b1;
      wait_clk(6);
      rst_n = 1'b1;
      wait_clk(6);
      check("R8", "reset enable", 16'(oe), 16'd0);
      check("R8", "reset data", 16'(miso), 16'd0);

      // Power-on flag reported once, then cleared.
      do_frame(6'h05, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R3");
      check("R6", "power_on first frame", 16'(last_stat[5]), 16'd1);
      do_frame(6'h05, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R3");
      check("R6", "power_on after good frame", 16'(last_stat[5]), 16'd0);

      // Write sweep over all addresses; each write returns old contents.
      for (int a = 0; a < 64; a++) begin
         d = 8'(a * 37 + 11);
         if (a == 0) d[0] = 1'b0;
         do_frame(6'(a), 1'b1, d, 16, 1'b0, a[0], a[1], "R3");
         check("R10", "self_test bit", 16'(last_stat[4]), 16'(a[0]));
         check("R10", "saturation bit", 16'(last_stat[3]), 16'(a[1]));
      end
      // Read sweep: implemented registers hold data, reserved read zero.
      for (int a = 0; a < 64; a++) begin
         do_frame(6'(a), 1'b0, 8'hA5, 16, 1'b0, 1'b0, 1'b0, (a < 8) ? "R1" : "R7");
      end
      // Second pass over implemented registers so each write result is seen.
      for (int a = 0; a < 8; a++) begin
         do_frame(6'(a), 1'b1, ~mem[a] & 8'hFE, 16, 1'b0, 1'b1, 1'b1, "R3");
      end

      // Bad parity write.
      d = mem[3];
      do_frame(6'h03, 1'b1, 8'h3C, 16, 1'b1, 1'b0, 1'b0, "R3");
      do_frame(6'h03, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R4");
      check("R5", "error after bad parity", 16'(last_stat[6]), 16'd1);
      check("R4", "parity error no write", 16'(last_data), 16'(d));
      do_frame(6'h03, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R4");
      check("R5", "error cleared after good frame", 16'(last_stat[6]), 16'd0);

      // Short and long frames.
      d = mem[4];
      do_frame(6'h04, 1'b1, 8'hC3, 12, 1'b0, 1'b0, 1'b0, "R3");
      do_frame(6'h04, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R4");
      check("R5", "error after short frame", 16'(last_stat[6]), 16'd1);
      check("R4", "short frame no write", 16'(last_data), 16'(d));
      do_frame(6'h04, 1'b1, 8'hC3, 17, 1'b0, 1'b0, 1'b0, "R3");
      do_frame(6'h04, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R4");
      check("R5", "error after long frame", 16'(last_stat[6]), 16'd1);
      check("R4", "long frame no write", 16'(last_data), 16'(d));

      // Two's-complement pair across two frames, each with its own parity.
      do_frame(6'h01, 1'b1, 8'hFF, 16, 1'b0, 1'b0, 1'b0, "R3");
      do_frame(6'h02, 1'b1, 8'h80, 16, 1'b0, 1'b0, 1'b0, "R3");
      do_frame(6'h01, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R1");
      check("R2", "parity high byte", 16'(last_stat[0]), 16'd1);
      do_frame(6'h02, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R1");
      check("R2", "parity low byte", 16'(last_stat[0]), 16'd0);

      // Output disable and broadcast write that clears it.
      do_frame(6'h00, 1'b1, 8'h01, 16, 1'b0, 1'b0, 1'b0, "R3");
      do_frame(6'h01, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R9");
      do_frame(6'h00, 1'b1, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R9");
      do_frame(6'h00, 1'b0, 8'h00, 16, 1'b0, 1'b0, 1'b0, "R9");
      check("R9", "control cleared by broadcast", 16'(last_data), 16'h0000);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule